// File: doc/BRIEF.md
# Per-Timeslot Transmit Channel Conditioner

This block sits on the transmit side of a 32-slot E1 frame and decides, for every timeslot as it passes, which byte goes out on the line. A small control store holds one configuration byte per timeslot. The outgoing byte can come from one of four sources:

- the system-side input byte, optionally with every second bit flipped;
- an idle code register written by the microprocessor;
- an A-law digital milliwatt tone;
- a 2^15-1 pseudo-random sequence.

Per timeslot, the block also drives the select lines that steer either the system input byte (local loopback) or the received line byte (remote loopback) onto the system output.

A timeslot index and a valid strobe arrive with each byte pair. They come with one global bit that chooses between tone and PRBS for every slot marked as test. All results appear one clock after the strobe. Timeslot 0 carries framing and is never conditioned. Writes to its control entry are discarded.

Top module: `tx_chan_cond`

## Requirements
- R1: After reset every control entry and the idle code are 0, and all outputs are 0. An unconfigured slot then transmits its system byte unchanged and outputs the line byte to the system side.
- R2: For a strobed slot, `tx_vld` is 1 exactly one clock after `slot_vld`, with that slot's results. With no strobe, `tx_vld` is 0.
- R3: When control bit 0 (alternate inversion) is set and nothing of higher priority is set, `tx_byte` equals the system byte XOR 8'h55.
- R4: When control bit 4 (idle select) is set and neither test nor remote loopback is set, `tx_byte` equals the idle code last written through `idle_we`/`idle_data`.
- R5: When control bit 3 (test) is set and `tone_mw_sel` is 1, `tx_byte` is the tone entry for the current frame. The tone cycles through 8'h34,21,21,34,B4,A1,A1,B4. It starts at the first entry after reset and advances after each strobed slot NUM_TS-1.
- R6: When control bit 3 is set and `tone_mw_sel` is 0, `tx_byte` is the next 8 bits of one shared x^15+x^14+1 generator. The generator is seeded all ones, and its first new bit goes to bit 7. It advances only on such slots.
- R7: When control bit 1 (local loopback) is set without remote loopback, `sys_out_byte` equals the system input byte and `lb_local` is 1. `tx_byte` is unaffected.
- R8: When control bit 2 (remote loopback) is set, both `tx_byte` and `sys_out_byte` equal the line byte, `lb_remote` is 1 and `lb_local` is 0. This holds whatever other bits are set.
- R9: Transmit priority is remote loopback, then test, then idle code, then inversion or plain system data.
- R10: Writes to control entry 0 are ignored, so timeslot 0 always transmits the system byte unchanged.
- R11: With neither loopback set, `sys_out_byte` equals the line byte, and both select outputs are 0. Control bits 7 to 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_idx | input | 5 | Timeslot number of the current byte pair |
| slot_vld | input | 1 | Byte pair strobe |
| sys_in_byte | input | 8 | Byte from the system side |
| line_rx_byte | input | 8 | Byte received from the line |
| tone_mw_sel | input | 1 | Test slots carry the tone (1) or the PRBS (0) |
| cfg_we | input | 1 | Control entry write enable |
| cfg_addr | input | 5 | Control entry index |
| cfg_data | input | 8 | Control byte |
| idle_we | input | 1 | Idle code write enable |
| idle_data | input | 8 | Idle code value |
| tx_byte | output | 8 | Byte to the line |
| tx_vld | output | 1 | Result strobe |
| sys_out_byte | output | 8 | Byte to the system side |
| lb_local | output | 1 | Local loopback select for this slot |
| lb_remote | output | 1 | Remote loopback select for this slot |

## Verification
The bench builds the block with its default of 32 timeslots. The 5-bit index then covers the whole frame, including the protected slot 0 and the frame boundary at slot 31. Ten tone frames wrap the 8-entry tone cycle, and PRBS slots in several frames show that the one shared generator skips over non-test slots. Slots combine several control bits, which exposes the priority order, and a write aimed at entry 0 shows that it is discarded.

// File: rtl/tx_cond_pkg.sv
package tx_cond_pkg;

    localparam int BYTE_W = 8;
    localparam int LFSR_W = 15;
    localparam logic [BYTE_W-1:0] ALT_MASK = 8'h55;

    // Bit order matches the control byte: bit4 down to bit0.
    typedef struct packed {
        logic idle_sel;
        logic test_en;
        logic rem_lb;
        logic loc_lb;
        logic alt_inv;
    } slot_ctl_t;

    function automatic slot_ctl_t ctl_from_byte(input logic [BYTE_W-1:0] b);
        return slot_ctl_t'(b[4:0]);
    endfunction

    function automatic logic [BYTE_W-1:0] tone_entry(input logic [2:0] i);
        logic [BYTE_W-1:0] r;
        case (i)
            3'd0, 3'd3: r = 8'h34;
            3'd1, 3'd2: r = 8'h21;
            3'd4, 3'd7: r = 8'hB4;
            default:    r = 8'hA1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tcc_ctl_store.sv
module tcc_ctl_store
    import tx_cond_pkg::*;
#(
    parameter int NUM_TS = 32,
    parameter int TS_W   = $clog2(NUM_TS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TS_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [TS_W-1:0]   rd_addr,
    output slot_ctl_t         rd_ctl
);

    slot_ctl_t ent_d [NUM_TS];
    slot_ctl_t ent_q [NUM_TS];

    // Entry 0 is the framing slot: it never takes a write.
    for (genvar g = 0; g < NUM_TS; g++) begin : g_entry
        if (g == 0) begin : g_locked
            assign ent_d[g] = '0;
        end else begin : g_writable
            always_comb begin
                ent_d[g] = ent_q[g];
                if (wr_en && (wr_addr == TS_W'(g)))
                    ent_d[g] = ctl_from_byte(wr_byte);
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_TS; i++) begin
            if (!rst_n) ent_q[i] <= '0;
            else        ent_q[i] <= ent_d[i];
        end
    end

    assign rd_ctl = ent_q[rd_addr];

    assert_slot0_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == '0) |-> (rd_ctl == '0));

endmodule

// File: rtl/tcc_pattern_gen.sv
module tcc_pattern_gen
    import tx_cond_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic              prbs_adv,
    output logic [BYTE_W-1:0] tone_byte,
    output logic [BYTE_W-1:0] prbs_byte
);

    typedef struct packed {
        logic [2:0]        tone_idx;
        logic [LFSR_W-1:0] lfsr;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic [LFSR_W-1:0] lfsr_adv;
    logic [BYTE_W-1:0] bits_out;

    always_comb begin
        logic fb;
        lfsr_adv = st_q.lfsr;
        bits_out = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = lfsr_adv[14] ^ lfsr_adv[13];
            lfsr_adv = {lfsr_adv[13:0], fb};
            bits_out[BYTE_W-1-i] = fb;
        end
        st_d = st_q;
        if (frame_end) st_d.tone_idx = st_q.tone_idx + 3'd1;
        if (prbs_adv)  st_d.lfsr = lfsr_adv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tone_idx <= '0;
            st_q.lfsr     <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tone_byte = tone_entry(st_q.tone_idx);
    assign prbs_byte = bits_out;

    assert_lfsr_alive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lfsr != '0);

    assert_lfsr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !prbs_adv |=> $stable(st_q.lfsr));

    assert_tone_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(st_q.tone_idx));

endmodule

// File: rtl/tx_chan_cond.sv
module tx_chan_cond
    import tx_cond_pkg::*;
#(
    parameter int NUM_TS = 32,
    parameter int TS_W   = $clog2(NUM_TS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   slot_idx,
    input  logic              slot_vld,
    input  logic [BYTE_W-1:0] sys_in_byte,
    input  logic [BYTE_W-1:0] line_rx_byte,
    input  logic              tone_mw_sel,
    input  logic              cfg_we,
    input  logic [TS_W-1:0]   cfg_addr,
    input  logic [BYTE_W-1:0] cfg_data,
    input  logic              idle_we,
    input  logic [BYTE_W-1:0] idle_data,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_vld,
    output logic [BYTE_W-1:0] sys_out_byte,
    output logic              lb_local,
    output logic              lb_remote
);

    localparam logic [TS_W-1:0] LAST_TS = TS_W'(NUM_TS - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] tx;
        logic              vld;
        logic [BYTE_W-1:0] sys_out;
        logic              loc;
        logic              rem;
        logic [BYTE_W-1:0] idle_code;
    } out_st_t;

    out_st_t   st_d, st_q;
    slot_ctl_t ctl;
    logic [BYTE_W-1:0] tone_byte, prbs_byte;
    logic frame_end, prbs_adv;

    tcc_ctl_store #(.NUM_TS(NUM_TS), .TS_W(TS_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_byte (cfg_data),
        .rd_addr (slot_idx),
        .rd_ctl  (ctl)
    );

    assign frame_end = slot_vld && (slot_idx == LAST_TS);
    assign prbs_adv  = slot_vld && ctl.test_en && !ctl.rem_lb && !tone_mw_sel;

    tcc_pattern_gen u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .prbs_adv  (prbs_adv),
        .tone_byte (tone_byte),
        .prbs_byte (prbs_byte)
    );

    always_comb begin
        st_d = st_q;
        st_d.vld = slot_vld;
        if (idle_we) st_d.idle_code = idle_data;
        if (slot_vld) begin
            if (ctl.rem_lb)        st_d.tx = line_rx_byte;
            else if (ctl.test_en)  st_d.tx = tone_mw_sel ? tone_byte : prbs_byte;
            else if (ctl.idle_sel) st_d.tx = st_q.idle_code;
            else if (ctl.alt_inv)  st_d.tx = sys_in_byte ^ ALT_MASK;
            else                   st_d.tx = sys_in_byte;
            st_d.sys_out = (ctl.loc_lb && !ctl.rem_lb) ? sys_in_byte : line_rx_byte;
            st_d.loc     = ctl.loc_lb && !ctl.rem_lb;
            st_d.rem     = ctl.rem_lb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_byte      = st_q.tx;
    assign tx_vld       = st_q.vld;
    assign sys_out_byte = st_q.sys_out;
    assign lb_local     = st_q.loc;
    assign lb_remote    = st_q.rem;

    assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_vld |=> tx_vld);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_vld |=> !tx_vld);

    assert_slot0_plain_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld && slot_idx == '0) |=> (tx_byte == $past(sys_in_byte)));

    assert_remote_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld && ctl.rem_lb) |=>
            (tx_byte == $past(line_rx_byte) && sys_out_byte == $past(line_rx_byte) && !lb_local));

endmodule

// File: tb/tx_chan_cond_test.sv
module tx_chan_cond_test;
    import tx_cond_pkg::*;

    logic clk = 0;
    logic rst_n = 0;
    logic [4:0] slot_idx = '0;
    logic slot_vld = 0;
    logic [7:0] sys_in_byte = '0, line_rx_byte = '0;
    logic tone_mw_sel = 0;
    logic cfg_we = 0;
    logic [4:0] cfg_addr = '0;
    logic [7:0] cfg_data = '0;
    logic idle_we = 0;
    logic [7:0] idle_data = '0;
    logic [7:0] tx_byte, sys_out_byte;
    logic tx_vld, lb_local, lb_remote;

    always #2.5 clk = ~clk;

    tx_chan_cond uut (.*);

    int checks = 0, errors = 0;
    bit finished = 0;

    // Reference model state
    logic [7:0]  m_ctl [32];
    logic [7:0]  m_idle = 8'h00;
    logic [2:0]  m_tone = 3'd0;
    logic [14:0] m_lfsr = '1;
    logic [25:0] exp_q [$];
    string       tag_q [$];

    function automatic logic [7:0] tone_ref(input logic [2:0] i);
        logic [7:0] t [8] = '{8'h34, 8'h21, 8'h21, 8'h34, 8'hB4, 8'hA1, 8'hA1, 8'hB4};
        return t[i];
    endfunction

    task automatic wr_ctl(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        slot_vld = 0; cfg_we = 1; cfg_addr = a; cfg_data = d;
        if (a != 0) m_ctl[a] = d;  // R10: entry 0 write discarded
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic wr_idle(input logic [7:0] d);
        @(negedge clk);
        slot_vld = 0; idle_we = 1; idle_data = d; m_idle = d;
        @(negedge clk);
        idle_we = 0;
    endtask

    task automatic send_slot(input logic [4:0] idx, input logic [7:0] sb,
                             input logic [7:0] lb, input logic tone);
        logic [7:0] c, tx, so;
        logic lo, re, fb;
        string tag;
        @(negedge clk);
        c = m_ctl[idx];
        re = c[2];
        lo = c[1] && !c[2];
        if (c[2]) tx = lb;
        else if (c[3]) begin
            if (tone) tx = tone_ref(m_tone);
            else begin
                for (int i = 7; i >= 0; i--) begin
                    fb = m_lfsr[14] ^ m_lfsr[13];
                    m_lfsr = {m_lfsr[13:0], fb};
                    tx[i] = fb;
                end
            end
        end
        else if (c[4]) tx = m_idle;
        else if (c[0]) tx = sb ^ 8'h55;
        else tx = sb;
        so = lo ? sb : lb;
        if (idx == 0) tag = "R10";
        else if (c[2]) tag = "R8";
        else if (c[3] && (c[4] || c[0])) tag = "R9";
        else if (c[3]) tag = tone ? "R5" : "R6";
        else if (c[4]) tag = "R4";
        else if (c[0]) tag = "R3";
        else if (c[1]) tag = "R7";
        else if (c[7:5] != 0) tag = "R11";
        else tag = "R1/R2";
        exp_q.push_back({tx, so, lo, re, 8'h00});
        tag_q.push_back(tag);
        slot_idx = idx; sys_in_byte = sb; line_rx_byte = lb; tone_mw_sel = tone;
        slot_vld = 1;
        if (idx == 5'd31) m_tone = m_tone + 3'd1;
    endtask

    task automatic run_frame(input logic tone, input int seed, input bit gaps);
        for (int s = 0; s < 32; s++) begin
            send_slot(5'(s), 8'((s * 37 + seed * 11) ^ 8'hA6), 8'((s * 53 + seed * 7) ^ 8'h3C), tone);
            if (gaps && (s % 5 == 4)) begin
                @(negedge clk);
                slot_vld = 0;
            end
        end
        @(negedge clk);
        slot_vld = 0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            if (tx_vld) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2: tx_vld=1 with nothing expected (actual tx=%h, expected none)", tx_byte);
                end else begin
                    logic [25:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if ({tx_byte, sys_out_byte, lb_local, lb_remote} != e[25:8]) begin
                        errors++;
                        $display("FAIL %s: actual tx=%h so=%h lo=%b re=%b expected tx=%h so=%h lo=%b re=%b",
                                 t, tx_byte, sys_out_byte, lb_local, lb_remote,
                                 e[25:18], e[17:10], e[9], e[8]);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) m_ctl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: outputs after reset
        checks++;
        if ({tx_byte, tx_vld, sys_out_byte, lb_local, lb_remote} != '0) begin
            errors++;
            $display("FAIL R1: actual tx=%h vld=%b so=%h expected all zero", tx_byte, tx_vld, sys_out_byte);
        end
        run_frame(1'b1, 1, 1'b0);          // R1, R2: all pass-through
        wr_ctl(5'd0, 8'h1F);               // R10: discarded
        wr_ctl(5'd1, 8'h01);               // R3
        wr_ctl(5'd2, 8'h02);               // R7
        wr_ctl(5'd3, 8'h04);               // R8
        wr_ctl(5'd4, 8'h08);               // R5/R6
        wr_ctl(5'd5, 8'h10);               // R4
        wr_ctl(5'd6, 8'h19);               // R9
        wr_ctl(5'd7, 8'h0E);               // R8 over local and test
        wr_ctl(5'd9, 8'h08);
        wr_ctl(5'd12, 8'hE0);              // R11: upper bits ignored
        wr_ctl(5'd20, 8'h11);              // R9: idle over inversion
        wr_ctl(5'd31, 8'h08);
        wr_idle(8'hC3);
        for (int f = 0; f < 10; f++) run_frame(1'b1, f + 2, f[0]);   // R5 wrap
        for (int f = 0; f < 3; f++) run_frame(1'b0, f + 20, 1'b1);   // R6 shared generator
        wr_idle(8'h5A);
        wr_ctl(5'd3, 8'h00);
        run_frame(1'b0, 40, 1'b0);
        run_frame(1'b1, 41, 1'b0);
        repeat (3) @(negedge clk);
        // R2: every expected item consumed
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2: actual %0d items left, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule